// File: doc/BRIEF.md
# Buffered PWM Timer

A 16-bit up/down counter with a period value and four compare channels. It produces four waveform outputs, four compare events and an overflow strobe. Software configures it through a small write port with one address per register. Period and compare values are never written directly into the registers the counter uses. Each value first lands in its own buffer, and all buffers are copied into the active set at an update point. A forced update command also performs this copy.

The counter steps on a tick from a prescaler that divides the clock by one of eight ratios. The waveform mode decides the count pattern, where the update point falls and how each waveform output is driven. The modes are normal, frequency generation, single-slope PWM and three dual-slope variants. Each compare event can be set to pulse on a match or to follow its channel's waveform level. Three commands act immediately: force an update, restart the count, or return the whole block to its power-on state.

Top module: `pwm_timer`

## Requirements
- R1: The write port decodes four kinds of address. Address 0 is control: bit 0 run, bits 3:1 prescale code, bits 6:4 mode, bit 7 direction (1 = down), and bits 8 to 11 the event-level select of channels 0 to 3. Address 1 is the command field in bits 1:0. Address 2 is the period buffer. Addresses 3 to 6 are the compare buffers of channels 0 to 3. A written value takes effect at the next clock edge.
- R2: Prescale codes 0 to 7 divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024. The divider restarts from zero whenever run is 0. The first tick falls in the N-th cycle after run reads 1, where N is the ratio, and the counter changes at the edge that ends that cycle.
- R3: Mode 0 is normal mode, and codes 2 and 4 behave the same way. Up-counting runs from 0 to the period and wraps to 0. Down-counting runs to 0 and wraps to the period. Every waveform output is driven low at each tick.
- R4: Mode 3 is single-slope PWM. It counts like normal mode. At each tick, each waveform output takes the value "count at that tick is below the channel's compare value".
- R5: Mode 1 is frequency generation. Compare 0 takes the place of the period as the wrap value. Waveform 0 toggles at every wrap, and waveforms 1 to 3 are driven low.
- R6: Modes 5, 6 and 7 are dual-slope. The counter climbs to the period, turns and descends to 0, then turns again; the direction bit is ignored. When the count equals a compare value at a tick, that channel's waveform is cleared while climbing and set while descending.
- R7: The update point is a wrap in modes 0 to 4. In dual-slope it is the turn at the period for mode 5, the turn at 0 for mode 7, and both turns for mode 6. The overflow output is high for the one cycle after each update point.
- R8: A value written to a buffer does not affect counting or waveforms until an update point. At that point all five buffers are copied to the active set. The tick that reaches the update point still uses the old active values.
- R9: When a channel's event-level select is 0, its event output is high for one cycle after each tick at which the count equals its active compare value. When the select is 1, the event output equals that channel's waveform output.
- R10: Command 1 copies every buffer into the active set at once, whether or not the counter is running.
- R11: Command 2 clears the counter, the waveforms, the event pulses, the overflow and the prescaler, and it suppresses that cycle's tick. Control and all buffered and active values are kept.
- R12: Command 3 and the reset input return everything to its power-on state. Control becomes 0, the period buffer and active period become all ones, the compare buffers and active compares become 0, and the count, the waveforms and the events become 0.
- R13: Between ticks, and while run is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cnt | output | 16 | Current count |
| wave | output | 4 | Waveform outputs, one per channel |
| evt | output | 4 | Compare events, one per channel |
| ovf | output | 1 | One-cycle strobe after each update point |

## Verification
Most wrong internal state in this block reaches `cnt` within one tick. A stale active period or a period copied too early moves the wrap value, so the first wrong value shows up at the wrap after the faulty copy. A wrong slope flag in dual-slope shows at the next turn, and it also shows in `wave` at the next compare match. Prescaler faults shift every counter step by whole cycles. The bench compares every port against a cycle-level model in every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/pwm_timer_pkg.sv
// Shared constants for the buffered PWM timer: mode codes, commands,
// register addresses and control bit positions.
// Assumes a 16-bit (or wider) write data path.
package pwm_timer_pkg;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_NORMAL    = 3'd0;
    localparam mode_t MODE_FREQ      = 3'd1;
    localparam mode_t MODE_SINGLE    = 3'd3;
    localparam mode_t MODE_DUAL_TOP  = 3'd5;
    localparam mode_t MODE_DUAL_BOTH = 3'd6;
    localparam mode_t MODE_DUAL_BOT  = 3'd7;

    localparam logic [1:0] CMD_NONE    = 2'd0;
    localparam logic [1:0] CMD_UPDATE  = 2'd1;
    localparam logic [1:0] CMD_RESTART = 2'd2;
    localparam logic [1:0] CMD_HARD    = 2'd3;

    localparam int ADR_CTRL     = 0;
    localparam int ADR_CMD      = 1;
    localparam int ADR_PER      = 2;
    localparam int ADR_CMP_BASE = 3;

    localparam int CTL_RUN  = 0;
    localparam int CTL_PSEL = 1;
    localparam int CTL_MODE = 4;
    localparam int CTL_DIR  = 7;
    localparam int CTL_EVW  = 8;

    // Number of low prescaler bits that must all be one for a tick.
    function automatic int pre_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 4;
            3'd5:    return 6;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic is_dual(input mode_t m);
        return (m == MODE_DUAL_TOP) || (m == MODE_DUAL_BOTH) || (m == MODE_DUAL_BOT);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: free-running divider that produces a one-cycle tick once
// every 2^shift cycles while run is set.
// Assumes PRE_W covers the largest shift (10 bits for divide by 1024).
module pwm_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] psel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Build the mask of low bits that select the division ratio (R2).
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < pre_shift(psel));
        end
    end

    // Count cycles while running; restart from zero when stopped or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && !clr && ((pre_q & mask) == mask);

endmodule

// File: rtl/pwm_regs.sv
// Register file: control, period and compare buffers, and the active
// period and compare values loaded from the buffers on load.
// Assumes DATA_W >= 16 so that all control fields fit in one word.
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hard,
    input  logic                        load,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    output logic                        run,
    output logic [2:0]                  psel,
    output mode_t                       mode,
    output logic                        dir,
    output logic [N_CH-1:0]             evwave,
    output logic [CNT_W-1:0]            per_q,
    output logic [N_CH-1:0][CNT_W-1:0]  cmp_q
);

    logic                       srst;
    logic [CNT_W-1:0]           per_buf;
    logic [N_CH-1:0][CNT_W-1:0] cmp_buf;

    assign srst = !rst_n || hard;

    // Control word: write in one access, cleared by reset or hard reset (R1, R12).
    always_ff @(posedge clk) begin
        if (srst) begin
            run    <= 1'b0;
            psel   <= '0;
            mode   <= MODE_NORMAL;
            dir    <= 1'b0;
            evwave <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL)) begin
            run    <= wr_data[CTL_RUN];
            psel   <= wr_data[CTL_PSEL +: 3];
            mode   <= wr_data[CTL_MODE +: 3];
            dir    <= wr_data[CTL_DIR];
            evwave <= wr_data[CTL_EVW +: N_CH];
        end
    end

    // Period buffer and active period; the active copy changes only on load (R8, R10).
    always_ff @(posedge clk) begin
        if (srst) begin
            per_buf <= '1;
            per_q   <= '1;
        end else begin
            if (load) per_q <= per_buf;
            if (wr_en && wr_addr == ADDR_W'(ADR_PER)) per_buf <= wr_data;
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        // Compare buffer and active compare of one channel (R8, R10).
        always_ff @(posedge clk) begin
            if (srst) begin
                cmp_buf[i] <= '0;
                cmp_q[i]   <= '0;
            end else begin
                if (load) cmp_q[i] <= cmp_buf[i];
                if (wr_en && wr_addr == ADDR_W'(ADR_CMP_BASE + i)) cmp_buf[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm_count_engine.sv
// Count engine: steps the counter on each tick according to the mode
// and flags the update point. Assumes top values are held stable by the
// register file between update points.
module pwm_count_engine
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  mode_t            mode,
    input  logic             dir,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp0,
    output logic [CNT_W-1:0] cnt_q,
    output logic             up_q,
    output logic             upd_pt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] nxt;
    logic             up_nxt;
    logic             at_top;
    logic             at_bot;
    logic             pt;

    // Work out the next count, slope and update point for this tick (R3-R7).
    always_comb begin
        top    = (mode == MODE_FREQ) ? cmp0 : per;
        nxt    = cnt_q;
        up_nxt = up_q;
        at_top = 1'b0;
        at_bot = 1'b0;
        pt     = 1'b0;
        if (is_dual(mode)) begin
            if (up_q) begin
                if (cnt_q >= per) begin
                    nxt    = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    up_nxt = 1'b0;
                    at_top = 1'b1;
                end else begin
                    nxt = cnt_q + ONE;
                end
            end else begin
                if (cnt_q == '0) begin
                    nxt    = (per == '0) ? '0 : ONE;
                    up_nxt = 1'b1;
                    at_bot = 1'b1;
                end else begin
                    nxt = cnt_q - ONE;
                end
            end
            case (mode)
                MODE_DUAL_TOP: pt = at_top;
                MODE_DUAL_BOT: pt = at_bot;
                default:       pt = at_top | at_bot;
            endcase
        end else if (!dir) begin
            if (cnt_q >= top) begin
                nxt = '0;
                pt  = 1'b1;
            end else begin
                nxt = cnt_q + ONE;
            end
        end else begin
            if (cnt_q == '0) begin
                nxt = top;
                pt  = 1'b1;
            end else begin
                nxt = cnt_q - ONE;
            end
        end
    end

    assign upd_pt = tick && pt;

    // Hold the count between ticks; clear on restart (R11, R13).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= nxt;
            up_q  <= up_nxt;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// Compare channel: drives one waveform output and one compare event
// from the shared count. Assumes cnt and up are the values before the tick.
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             upd_pt,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic [CNT_W-1:0] cmp,
    input  logic             evwave,
    output logic             wave,
    output logic             evt
);

    logic match;
    logic pulse_q;

    assign match = tick && (cnt == cmp);

    // Update waveform level and match pulse on each tick (R3-R6, R9).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wave    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= match;
            if (tick) begin
                case (mode)
                    MODE_SINGLE: wave <= (cnt < cmp);
                    MODE_FREQ:   wave <= (IDX == 0) ? (wave ^ upd_pt) : 1'b0;
                    MODE_DUAL_TOP, MODE_DUAL_BOTH, MODE_DUAL_BOT: begin
                        if (match) wave <= !up;
                    end
                    default:     wave <= 1'b0;
                endcase
            end
        end
    end

    assign evt = evwave ? wave : pulse_q;

endmodule

// File: rtl/pwm_timer.sv
// Buffered PWM timer top: decodes commands and connects the prescaler,
// register file, count engine and compare channels.
// Assumes one register access per cycle on a plain write strobe.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int N_CH   = 4,
    parameter  int PRE_W  = 10,
    localparam int ADDR_W = $clog2(N_CH + ADR_CMP_BASE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic [N_CH-1:0]   wave,
    output logic [N_CH-1:0]   evt,
    output logic              ovf
);

    logic                       cmd_wr;
    logic                       force_upd;
    logic                       restart;
    logic                       hard;
    logic                       clr;
    logic                       load;
    logic                       tick;
    logic                       upd_pt;
    logic                       up;
    logic                       run;
    logic [2:0]                 psel;
    mode_t                      mode;
    logic                       dir;
    logic [N_CH-1:0]            evwave;
    logic [CNT_W-1:0]           per_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_q;

    // Decode the command field of a write to the command address (R10-R12).
    always_comb begin
        cmd_wr    = wr_en && (wr_addr == ADDR_W'(ADR_CMD));
        force_upd = cmd_wr && (wr_data[1:0] == CMD_UPDATE);
        restart   = cmd_wr && (wr_data[1:0] == CMD_RESTART);
        hard      = cmd_wr && (wr_data[1:0] == CMD_HARD);
    end

    assign clr  = restart || hard;
    assign load = force_upd || upd_pt;

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (clr),
        .psel  (psel),
        .tick  (tick)
    );

    pwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hard    (hard),
        .load    (load),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run),
        .psel    (psel),
        .mode    (mode),
        .dir     (dir),
        .evwave  (evwave),
        .per_q   (per_q),
        .cmp_q   (cmp_q)
    );

    pwm_count_engine #(.CNT_W(CNT_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (clr),
        .mode   (mode),
        .dir    (dir),
        .per    (per_q),
        .cmp0   (cmp_q[0]),
        .cnt_q  (cnt),
        .up_q   (up),
        .upd_pt (upd_pt)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W), .IDX(i)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .tick   (tick),
            .upd_pt (upd_pt),
            .mode   (mode),
            .cnt    (cnt),
            .up     (up),
            .cmp    (cmp_q[i]),
            .evwave (evwave[i]),
            .wave   (wave[i]),
            .evt    (evt[i])
        );
    end

    // Overflow strobe one cycle after each update point (R7).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf <= 1'b0;
        end else begin
            ovf <= upd_pt;
        end
    end

endmodule

// File: rtl/pwm_timer_chk.sv
// Assertion checker for pwm_timer, attached by bind below.
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             clr,
    input logic             upd_pt,
    input mode_t            mode,
    input logic [N_CH-1:0]  evwave,
    input logic [CNT_W-1:0] cnt,
    input logic [N_CH-1:0]  wave,
    input logic [N_CH-1:0]  evt,
    input logic             ovf
);

    // R13
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

    // R7
    ovf_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(tick));

    // R3
    normal_wave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_NORMAL) |=> (wave == '0));

    // R5
    freq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pt && mode == MODE_FREQ) |=> (wave[0] != $past(wave[0])));

    // R9
    pulse_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[0] && !evwave[0]) |-> $past(tick));

    // R11
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && wave == '0 && !ovf));

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (clr),
    .upd_pt (upd_pt),
    .mode   (mode),
    .evwave (evwave),
    .cnt    (cnt),
    .wave   (wave),
    .evt    (evt),
    .ovf    (ovf)
);

// File: tb/pwm_timer_test.sv
// Bench for pwm_timer: directed corner cases plus seeded random register
// traffic, compared every cycle against a cycle-level model.
module pwm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt;
    logic [3:0]  wave;
    logic [3:0]  evt;
    logic        ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt(cnt), .wave(wave), .evt(evt), .ovf(ovf)
    );

    // ---------------- model state ----------------
    logic        m_run, m_dir;
    logic [2:0]  m_psel, m_mode;
    logic [3:0]  m_evw;
    logic [15:0] m_perb, m_per;
    logic [15:0] m_cmpb [4];
    logic [15:0] m_cmp  [4];
    logic [9:0]  m_pre;
    logic [15:0] m_cnt;
    logic        m_up;
    logic [3:0]  m_wave, m_pulse;
    logic        m_ovf;

    function automatic int shift_of(input logic [2:0] s);
        case (s)
            3'd0: return 0; 3'd1: return 1; 3'd2: return 2; 3'd3: return 3;
            3'd4: return 4; 3'd5: return 6; 3'd6: return 8; default: return 10;
        endcase
    endfunction

    function automatic logic [15:0] ctl(input logic [3:0] evw, input logic d,
                                        input logic [2:0] md, input logic [2:0] ps,
                                        input logic r);
        return {4'h0, evw, d, md, ps, r};
    endfunction

    task automatic m_reset();
        m_run = 0; m_dir = 0; m_psel = 0; m_mode = 0; m_evw = 0;
        m_perb = 16'hFFFF; m_per = 16'hFFFF;
        for (int i = 0; i < 4; i++) begin m_cmpb[i] = 0; m_cmp[i] = 0; end
        m_pre = 0; m_cnt = 0; m_up = 1; m_wave = 0; m_pulse = 0; m_ovf = 0;
    endtask

    initial m_reset();

    logic        t_tk, t_pt, t_at, t_ab, t_upn, t_dual, t_rs, t_fu;
    logic [15:0] t_top, t_nxt;
    logic [9:0]  t_mask;
    logic [3:0]  t_nw, t_np;

    // Reference model, one step per clock edge from the values before it.
    always @(posedge clk) begin
        if (!rst_n || (wr_en && wr_addr == 3'd1 && wr_data[1:0] == 2'd3)) begin
            m_reset();
        end else begin
            t_rs   = wr_en && wr_addr == 3'd1 && wr_data[1:0] == 2'd2;
            t_fu   = wr_en && wr_addr == 3'd1 && wr_data[1:0] == 2'd1;
            t_mask = 10'((1 << shift_of(m_psel)) - 1);
            t_tk   = m_run && !t_rs && ((m_pre & t_mask) == t_mask);
            t_dual = (m_mode == 5) || (m_mode == 6) || (m_mode == 7);
            t_top  = (m_mode == 1) ? m_cmp[0] : m_per;
            t_nxt = m_cnt; t_upn = m_up; t_at = 0; t_ab = 0; t_pt = 0;
            if (t_dual) begin
                if (m_up) begin
                    if (m_cnt >= m_per) begin
                        t_nxt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; t_upn = 0; t_at = 1;
                    end else t_nxt = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 0) begin
                        t_nxt = (m_per == 0) ? 16'd0 : 16'd1; t_upn = 1; t_ab = 1;
                    end else t_nxt = m_cnt - 16'd1;
                end
                t_pt = (m_mode == 5) ? t_at : (m_mode == 7) ? t_ab : (t_at | t_ab);
            end else if (!m_dir) begin
                if (m_cnt >= t_top) begin t_nxt = 0; t_pt = 1; end
                else t_nxt = m_cnt + 16'd1;
            end else begin
                if (m_cnt == 0) begin t_nxt = t_top; t_pt = 1; end
                else t_nxt = m_cnt - 16'd1;
            end
            t_nw = m_wave;
            for (int i = 0; i < 4; i++) begin
                t_np[i] = t_tk && (m_cnt == m_cmp[i]);
                if (t_tk) begin
                    case (m_mode)
                        3'd3: t_nw[i] = (m_cnt < m_cmp[i]);
                        3'd1: t_nw[i] = (i == 0) ? (m_wave[0] ^ t_pt) : 1'b0;
                        3'd5, 3'd6, 3'd7: if (m_cnt == m_cmp[i]) t_nw[i] = !m_up;
                        default: t_nw[i] = 1'b0;
                    endcase
                end
            end
            m_wave = t_nw; m_pulse = t_np; m_ovf = t_tk && t_pt;
            if (t_tk) begin m_cnt = t_nxt; m_up = t_upn; end
            if (t_fu || (t_tk && t_pt)) begin
                m_per = m_perb;
                for (int i = 0; i < 4; i++) m_cmp[i] = m_cmpb[i];
            end
            m_pre = (!m_run || t_rs) ? 10'd0 : m_pre + 10'd1;
            if (wr_en) begin
                if (wr_addr == 3'd0) begin
                    m_run = wr_data[0]; m_psel = wr_data[3:1]; m_mode = wr_data[6:4];
                    m_dir = wr_data[7]; m_evw = wr_data[11:8];
                end
                if (wr_addr == 3'd2) m_perb = wr_data;
                for (int i = 0; i < 4; i++)
                    if (wr_addr == 3'(3 + i)) m_cmpb[i] = wr_data;
            end
            if (t_rs) begin
                m_cnt = 0; m_up = 1; m_wave = 0; m_pulse = 0; m_ovf = 0;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1: return "R5 freq";
            3'd3: return "R4 single";
            3'd5, 3'd6, 3'd7: return "R6 dual";
            default: return "R3 normal";
        endcase
    endfunction

    task automatic compare_all();
        logic [3:0] e_evt;
        for (int i = 0; i < 4; i++) e_evt[i] = m_evw[i] ? m_wave[i] : m_pulse[i];
        chk({mode_tag(m_mode), " cnt"}, 32'(cnt), 32'(m_cnt));
        chk({mode_tag(m_mode), " wave"}, 32'(wave), 32'(m_wave));
        chk("R9 evt", 32'(evt), 32'(e_evt));
        chk("R7 ovf", 32'(ovf), 32'(m_ovf));
    endtask

    // Advance one cycle: wait for the falling edge, compare, release the port.
    task automatic cyc();
        @(negedge clk);
        if (rst_n) compare_all();
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    localparam logic [2:0] MODE_PICK [6] = '{3'd0, 3'd1, 3'd3, 3'd5, 3'd6, 3'd7};

    initial begin
        logic [15:0] held;
        void'($urandom(32'd2024));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R12 reset cnt", 32'(cnt), 32'd0);
        chk("R12 reset wave", 32'(wave), 32'd0);
        chk("R12 reset evt", 32'(evt), 32'd0);

        // R1 R2: divide by 4, single-slope up
        wr(3'd0, ctl(4'h0, 1'b0, 3'd3, 3'd2, 1'b1));
        repeat (3) cyc();
        chk("R1 R2 no step before 4th cycle", 32'(cnt), 32'd0);
        cyc();
        chk("R2 first step", 32'(cnt), 32'd1);
        repeat (3) cyc();
        chk("R2 hold between ticks", 32'(cnt), 32'd1);
        cyc();
        chk("R2 second step", 32'(cnt), 32'd2);

        // R10: forced update while stopped, then single-slope down
        wr(3'd1, 16'd3);
        wr(3'd0, ctl(4'h0, 1'b1, 3'd3, 3'd0, 1'b0));
        wr(3'd2, 16'd7);
        wr(3'd1, 16'd1);
        wr(3'd0, ctl(4'h0, 1'b1, 3'd3, 3'd0, 1'b1));
        cyc();
        chk("R10 forced period used at first wrap", 32'(cnt), 32'd7);
        cyc();
        chk("R10 count down", 32'(cnt), 32'd6);

        // R8: buffered period waits for the update point
        wr(3'd2, 16'd3);
        repeat (5) cyc();
        chk("R8 reaches zero", 32'(cnt), 32'd0);
        cyc();
        chk("R8 wrap uses old period", 32'(cnt), 32'd7);
        repeat (7) cyc();
        cyc();
        chk("R8 next wrap uses new period", 32'(cnt), 32'd3);

        // R11: restart keeps config
        wr(3'd0, ctl(4'h0, 1'b0, 3'd3, 3'd0, 1'b1));
        repeat (2) cyc();
        wr(3'd1, 16'd2);
        chk("R11 restart count", 32'(cnt), 32'd0);
        chk("R11 restart wave", 32'(wave), 32'd0);
        cyc();
        chk("R11 counts on after restart", 32'(cnt), 32'd1);

        // R12: hard reset clears buffers
        wr(3'd1, 16'd3);
        chk("R12 hard cnt", 32'(cnt), 32'd0);
        chk("R12 hard ovf", 32'(ovf), 32'd0);
        wr(3'd0, ctl(4'h0, 1'b1, 3'd3, 3'd0, 1'b1));
        cyc();
        chk("R12 period back to all ones", 32'(cnt), 32'hFFFF);

        // R13: stopped counter holds
        wr(3'd0, ctl(4'h0, 1'b1, 3'd3, 3'd0, 1'b0));
        held = cnt;
        repeat (10) cyc();
        chk("R13 hold while stopped", 32'(cnt), 32'(held));

        // R5: frequency generation with compare 0 as wrap value
        wr(3'd1, 16'd3);
        wr(3'd3, 16'd3);
        wr(3'd1, 16'd1);
        wr(3'd0, ctl(4'h1, 1'b0, 3'd1, 3'd0, 1'b1));
        repeat (5) cyc();
        chk("R5 wave0 toggled at first wrap", 32'(wave[0]), 32'd1);
        repeat (20) cyc();

        // R6 R7: dual-slope, both turns
        wr(3'd2, 16'd4);
        wr(3'd4, 16'd2);
        wr(3'd1, 16'd1);
        wr(3'd0, ctl(4'h2, 1'b0, 3'd6, 3'd0, 1'b1));
        repeat (30) cyc();

        // Random traffic
        for (int k = 0; k < 5000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 10) begin
                logic [2:0]  a;
                logic [15:0] d;
                a = 3'($urandom % 8);
                case (a)
                    3'd0: d = ctl(4'($urandom), 1'($urandom), MODE_PICK[$urandom % 6],
                                  3'($urandom % 3), ($urandom % 10) != 0);
                    3'd1: d = (($urandom % 100) < 4) ? 16'd3 : 16'($urandom % 3);
                    default: d = 16'($urandom % 18);
                endcase
                wr(a, d);
            end else begin
                cyc();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(1_900_000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R13 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule